// File: doc/BRIEF.md
# Execute Check Stage with Recovery Routing

This block sits in the execute step of a checker that validates instructions as they retire. In each cycle it takes one packet predicted by the core: an opcode, two source operands, a destination register number and the core's claimed ALU result. The block computes the integer operation again and reports whether the claim holds. It covers add, subtract, three bitwise logic operations and two shifts. Every unit receives the operands in parallel, and the opcode then selects one result.

A single mode input drives a routing multiplexer that sets the role of the block. In check mode the operands come from the core packet and the block compares its own result against the prediction. In recovery mode the operands come from the previous checker stage, and the computed result moves on to the next stage as an ordinary serial execute step. The comparator stays connected in both modes, but it is gated so that it can never raise a fault during recovery. A stall input freezes the output register, which lets any blocked stage hold the entire checker.

Top module: `exec_verify_stage`

## Requirements
- R1: When recover=0 and the selected valid is high, out_ok is 1 exactly when the opcode is legal and the computed result equals core_pred. In that case out_fault is 0. Otherwise out_ok is 0 and out_fault is 1.
- R2: When recover=0 the opcode, operands, destination and valid come from the core_* inputs. When recover=1 they come from the prev_* inputs, and the unused side has no effect on the outputs.
- R3: The opcode is 4 bits wide with this encoding:
  - 0: add
  - 1: subtract (a minus b)
  - 2: AND
  - 3: OR
  - 4: XOR
  - 5: shift left
  - 6: logical shift right

  Add and subtract wrap modulo 2^DATA_W. The shift amount is the low $clog2(DATA_W) bits of operand b.
- R4: When recover=1, out_fault is always 0. For a legal opcode with valid high, out_ok is 1 whatever value core_pred holds.
- R5: Opcodes 7 to 15 give a result of 0 and out_ok=0. In check mode they also give out_fault=1.
- R6: While stall is high, every output keeps its previous value across clock edges.
- R7: When the selected valid is low, out_valid, out_ok and out_fault are all 0 after the edge.
- R8: The output packet (valid, opcode, destination, result, ok, fault) is registered. It appears one clock edge after the inputs are sampled.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Holds the output register |
| recover | input | 1 | 0 selects check mode, 1 selects recovery mode |
| core_valid | input | 1 | Core packet valid |
| core_op | input | 4 | Core opcode |
| core_src_a | input | DATA_W | Core operand A |
| core_src_b | input | DATA_W | Core operand B |
| core_dst | input | DST_W | Core destination number |
| core_pred | input | DATA_W | Core predicted result |
| prev_valid | input | 1 | Previous-stage valid |
| prev_op | input | 4 | Previous-stage opcode |
| prev_src_a | input | DATA_W | Previous-stage operand A |
| prev_src_b | input | DATA_W | Previous-stage operand B |
| prev_dst | input | DST_W | Previous-stage destination |
| out_valid | output | 1 | Output packet valid |
| out_op | output | 4 | Forwarded opcode |
| out_dst | output | DST_W | Forwarded destination |
| out_result | output | DATA_W | Computed result |
| out_ok | output | 1 | Prediction confirmed (or legal op in recovery) |
| out_fault | output | 1 | Prediction mismatch in check mode |

## Verification
The bench builds the block with DATA_W=4 and DST_W=3. At that size, all 16 opcodes, including every illegal code, can be crossed with every pair of operands in both modes. The same setting makes every shift amount reachable, along with carry and borrow wrap at the word edge. In check mode each operand pair is applied twice: once with the true result as the prediction and once with a corrupted one. In recovery mode the core side carries conflicting garbage, to show that it is ignored.

// File: rtl/evs_pkg.sv
package evs_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6
    } evs_op_e;

    localparam int NUM_UNITS = 7;
endpackage

// File: rtl/evs_route.sv
module evs_route #(
    parameter int DATA_W = 32,
    parameter int DST_W  = 5
) (
    input  logic                     recover,
    input  logic                     core_valid,
    input  logic [evs_pkg::OP_W-1:0] core_op,
    input  logic [DATA_W-1:0]        core_src_a,
    input  logic [DATA_W-1:0]        core_src_b,
    input  logic [DST_W-1:0]         core_dst,
    input  logic                     prev_valid,
    input  logic [evs_pkg::OP_W-1:0] prev_op,
    input  logic [DATA_W-1:0]        prev_src_a,
    input  logic [DATA_W-1:0]        prev_src_b,
    input  logic [DST_W-1:0]         prev_dst,
    output logic                     sel_valid,
    output logic [evs_pkg::OP_W-1:0] sel_op,
    output logic [DATA_W-1:0]        sel_a,
    output logic [DATA_W-1:0]        sel_b,
    output logic [DST_W-1:0]         sel_dst
);
    always_comb begin
        if (recover) begin
            sel_valid = prev_valid;
            sel_op    = prev_op;
            sel_a     = prev_src_a;
            sel_b     = prev_src_b;
            sel_dst   = prev_dst;
        end else begin
            sel_valid = core_valid;
            sel_op    = core_op;
            sel_a     = core_src_a;
            sel_b     = core_src_b;
            sel_dst   = core_dst;
        end
    end
endmodule

// File: rtl/evs_alu.sv
module evs_alu #(
    parameter int DATA_W = 32
) (
    input  logic [evs_pkg::OP_W-1:0] op,
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    output logic [DATA_W-1:0]        result,
    output logic                     legal
);
    import evs_pkg::*;

    localparam int SHAMT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0]  unit_res [NUM_UNITS];
    logic [SHAMT_W-1:0] shamt;

    assign shamt = b[SHAMT_W-1:0];

    // every unit sees the operands in parallel
    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            always_comb begin
                case (u)
                    0:       unit_res[u] = a + b;
                    1:       unit_res[u] = a - b;
                    2:       unit_res[u] = a & b;
                    3:       unit_res[u] = a | b;
                    4:       unit_res[u] = a ^ b;
                    5:       unit_res[u] = a << shamt;
                    default: unit_res[u] = a >> shamt;
                endcase
            end
        end
    endgenerate

    // late selection by opcode
    always_comb begin
        result = '0;
        legal  = 1'b1;
        case (op)
            OP_ADD:  result = unit_res[0];
            OP_SUB:  result = unit_res[1];
            OP_AND:  result = unit_res[2];
            OP_OR:   result = unit_res[3];
            OP_XOR:  result = unit_res[4];
            OP_SLL:  result = unit_res[5];
            OP_SRL:  result = unit_res[6];
            default: legal  = 1'b0;
        endcase
    end
endmodule

// File: rtl/evs_compare.sv
module evs_compare #(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  logic              check_mode,
    input  logic              legal,
    input  logic [DATA_W-1:0] computed,
    input  logic [DATA_W-1:0] predicted,
    output logic              ok,
    output logic              fault
);
    logic match;

    always_comb begin
        match = legal && (computed == predicted);
        if (!valid) begin
            ok    = 1'b0;
            fault = 1'b0;
        end else if (check_mode) begin
            ok    = match;
            fault = !match;
        end else begin
            // recovery: inputs are trusted, the comparator stays mute
            ok    = legal;
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/exec_verify_stage.sv
module exec_verify_stage #(
    parameter int DATA_W = 32,
    parameter int DST_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              recover,
    input  logic              core_valid,
    input  logic [3:0]        core_op,
    input  logic [DATA_W-1:0] core_src_a,
    input  logic [DATA_W-1:0] core_src_b,
    input  logic [DST_W-1:0]  core_dst,
    input  logic [DATA_W-1:0] core_pred,
    input  logic              prev_valid,
    input  logic [3:0]        prev_op,
    input  logic [DATA_W-1:0] prev_src_a,
    input  logic [DATA_W-1:0] prev_src_b,
    input  logic [DST_W-1:0]  prev_dst,
    output logic              out_valid,
    output logic [3:0]        out_op,
    output logic [DST_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_result,
    output logic              out_ok,
    output logic              out_fault
);
    import evs_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [DST_W-1:0]  dst;
        logic [DATA_W-1:0] result;
        logic              ok;
        logic              fault;
    } stage_t;

    stage_t stage_d, stage_q;

    logic              sel_valid;
    logic [OP_W-1:0]   sel_op;
    logic [DATA_W-1:0] sel_a, sel_b;
    logic [DST_W-1:0]  sel_dst;
    logic [DATA_W-1:0] alu_res;
    logic              alu_legal;
    logic              cmp_ok, cmp_fault;

    evs_route #(.DATA_W(DATA_W), .DST_W(DST_W)) u_route (
        .recover    (recover),
        .core_valid (core_valid),
        .core_op    (core_op),
        .core_src_a (core_src_a),
        .core_src_b (core_src_b),
        .core_dst   (core_dst),
        .prev_valid (prev_valid),
        .prev_op    (prev_op),
        .prev_src_a (prev_src_a),
        .prev_src_b (prev_src_b),
        .prev_dst   (prev_dst),
        .sel_valid  (sel_valid),
        .sel_op     (sel_op),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .sel_dst    (sel_dst)
    );

    evs_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (sel_op),
        .a      (sel_a),
        .b      (sel_b),
        .result (alu_res),
        .legal  (alu_legal)
    );

    evs_compare #(.DATA_W(DATA_W)) u_cmp (
        .valid      (sel_valid),
        .check_mode (!recover),
        .legal      (alu_legal),
        .computed   (alu_res),
        .predicted  (core_pred),
        .ok         (cmp_ok),
        .fault      (cmp_fault)
    );

    always_comb begin
        stage_d = stage_q;
        if (!stall) begin
            stage_d.valid  = sel_valid;
            stage_d.op     = sel_op;
            stage_d.dst    = sel_dst;
            stage_d.result = alu_res;
            stage_d.ok     = cmp_ok;
            stage_d.fault  = cmp_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid  = stage_q.valid;
    assign out_op     = stage_q.op;
    assign out_dst    = stage_q.dst;
    assign out_result = stage_q.result;
    assign out_ok     = stage_q.ok;
    assign out_fault  = stage_q.fault;
endmodule

// File: rtl/exec_verify_stage_chk.sv
module exec_verify_stage_chk #(
    parameter int DATA_W = 32,
    parameter int DST_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              recover,
    input logic              core_valid,
    input logic              prev_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [DST_W-1:0]  out_dst,
    input logic              out_ok,
    input logic              out_fault
);
    AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ok && out_fault)); // R1

    AST_VALID_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall)) |->
        (out_valid == ($past(recover) ? $past(prev_valid) : $past(core_valid)))); // R2

    AST_NO_FAULT_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall) && $past(recover)) |-> !out_fault); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stall)) |->
        ($stable(out_valid) && $stable(out_result) && $stable(out_dst)
         && $stable(out_ok) && $stable(out_fault))); // R6

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ok && !out_fault)); // R7
endmodule

bind exec_verify_stage exec_verify_stage_chk #(.DATA_W(DATA_W), .DST_W(DST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .recover    (recover),
    .core_valid (core_valid),
    .prev_valid (prev_valid),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_dst    (out_dst),
    .out_ok     (out_ok),
    .out_fault  (out_fault)
);

// File: tb/exec_verify_stage_test.sv
module exec_verify_stage_test;
    localparam int DW = 4;
    localparam int RW = 3;
    localparam int PW = 1 + 4 + RW + DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0, recover = 1'b0;
    logic core_valid = 1'b0, prev_valid = 1'b0;
    logic [3:0] core_op = '0, prev_op = '0;
    logic [DW-1:0] core_src_a = '0, core_src_b = '0, core_pred = '0;
    logic [DW-1:0] prev_src_a = '0, prev_src_b = '0;
    logic [RW-1:0] core_dst = '0, prev_dst = '0;
    logic out_valid, out_ok, out_fault;
    logic [3:0] out_op;
    logic [RW-1:0] out_dst;
    logic [DW-1:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exec_verify_stage #(.DATA_W(DW), .DST_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .recover(recover),
        .core_valid(core_valid), .core_op(core_op), .core_src_a(core_src_a),
        .core_src_b(core_src_b), .core_dst(core_dst), .core_pred(core_pred),
        .prev_valid(prev_valid), .prev_op(prev_op), .prev_src_a(prev_src_a),
        .prev_src_b(prev_src_b), .prev_dst(prev_dst),
        .out_valid(out_valid), .out_op(out_op), .out_dst(out_dst),
        .out_result(out_result), .out_ok(out_ok), .out_fault(out_fault)
    );

    // R3, R5: arithmetic reference model
    function automatic logic [DW-1:0] ref_alu(int op, int a, int b);
        int s = b % DW;
        case (op)
            0: return DW'((a + b) % 16);
            1: return DW'((a - b + 16) % 16);
            2: return DW'(a & b);
            3: return DW'(a | b);
            4: return DW'(a ^ b);
            5: return DW'((a << s) % 16);
            6: return DW'(a >> s);
            default: return '0;
        endcase
    endfunction

    function automatic logic [PW-1:0] pack(logic v, logic [3:0] op, logic [RW-1:0] d,
                                           logic [DW-1:0] r, logic ok, logic f);
        return {v, op, d, r, ok, f};
    endfunction

    task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] outs();
        return pack(out_valid, out_op, out_dst, out_result, out_ok, out_fault);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r;
        logic legal;
        // R9: reset state, with live inputs present
        core_valid = 1'b1; core_op = 4'd3; core_src_a = 4'd5;
        step();
        chk("R9", outs(), '0);
        rst_n = 1'b1;

        // R1 R3 R5 R8: check mode sweep, true and corrupted prediction
        recover = 1'b0;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int bad = 0; bad < 2; bad++) begin
                        r = ref_alu(op, a, b);
                        legal = (op < 7);
                        core_valid = 1'b1;
                        core_op = 4'(op); core_src_a = DW'(a); core_src_b = DW'(b);
                        core_dst = RW'(a ^ b);
                        core_pred = (bad != 0) ? (r ^ 4'h9) : r;
                        prev_valid = 1'b0; prev_op = 4'(15 - op);
                        prev_src_a = DW'(b); prev_src_b = DW'(a); prev_dst = '1;
                        step();
                        chk(legal ? "R1" : "R5", outs(),
                            pack(1'b1, 4'(op), RW'(a ^ b), r,
                                 legal && bad == 0, !(legal && bad == 0)));
                    end
                end
            end
        end

        // R2 R4: recovery sweep, core side carries conflicting data
        recover = 1'b1;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    r = ref_alu(op, a, b);
                    prev_valid = 1'b1;
                    prev_op = 4'(op); prev_src_a = DW'(a); prev_src_b = DW'(b);
                    prev_dst = RW'(a + b);
                    core_valid = 1'b0; core_op = 4'(op ^ 1);
                    core_src_a = DW'(~a); core_src_b = DW'(b + 3);
                    core_dst = RW'(~(a + b)); core_pred = r ^ 4'h5;
                    step();
                    chk("R4", outs(), pack(1'b1, 4'(op), RW'(a + b), r, op < 7, 1'b0));
                end
            end
        end

        // R6: stall holds the last packet while inputs change
        recover = 1'b0;
        core_valid = 1'b1; core_op = 4'd0; core_src_a = 4'd9; core_src_b = 4'd9;
        core_dst = 3'd4; core_pred = 4'd2;
        step();
        chk("R8", outs(), pack(1'b1, 4'd0, 3'd4, 4'd2, 1'b1, 1'b0));
        stall = 1'b1;
        core_op = 4'd1; core_src_a = 4'd1; core_src_b = 4'd2; core_pred = 4'd0;
        core_dst = 3'd1;
        step();
        chk("R6", outs(), pack(1'b1, 4'd0, 3'd4, 4'd2, 1'b1, 1'b0));
        recover = 1'b1; prev_valid = 1'b0;
        step();
        chk("R6", outs(), pack(1'b1, 4'd0, 3'd4, 4'd2, 1'b1, 1'b0));
        stall = 1'b0; recover = 1'b0;
        step();
        chk("R6", outs(), pack(1'b1, 4'd1, 3'd1, 4'd15, 1'b0, 1'b1));

        // R7: valid low clears flags in both modes
        core_valid = 1'b0; core_pred = 4'd7;
        step();
        chk("R7", {out_valid, out_ok, out_fault}, 3'b000);
        recover = 1'b1; prev_valid = 1'b0; prev_op = 4'd12;
        step();
        chk("R7", {out_valid, out_ok, out_fault}, 3'b000);

        // R2: in check mode the prev side is ignored
        recover = 1'b0; core_valid = 1'b1; core_op = 4'd4;
        core_src_a = 4'hA; core_src_b = 4'h6; core_dst = 3'd2; core_pred = 4'hC;
        prev_valid = 1'b1; prev_op = 4'd0; prev_src_a = 4'h1; prev_src_b = 4'h1;
        prev_dst = 3'd7;
        step();
        chk("R2", outs(), pack(1'b1, 4'd4, 3'd2, 4'hC, 1'b1, 1'b0));

        // R9: asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        chk("R9", outs(), '0);
        finish_run();
    end
endmodule